// File: doc/BRIEF.md
# Edge Change Detection Interrupt Unit

This block watches a bank of digital input lines, grouped into byte-wide ports, and tells software when any of them changes. Every line carries two enable bits of its own, one for upward transitions and one for downward ones. Two global selects in the control register further gate each kind of transition. A transition that passes both gates sets a sticky change flag. If another qualifying transition arrives while that flag is still set, a second sticky flag records that a change was missed.

Software works through a byte-wide register bus with an address, a write strobe, write data and registered read data. It can program the per-port enables, read the flags, clear each flag independently by writing ones, and choose which flags drive the interrupt line. Each input is passed through a synchroniser before edge detection, so asynchronous field signals can be wired straight in. After reset the control register holds zero, and no interrupt can be generated until software programs it.

Top module: `chg_irq_unit`

## Requirements
- R1: After reset the interrupt output is 0, the status register (offset 0x02) reads 0, the control register (offset 0x03) reads 0, every per-port enable register reads 0, and offset 0x00 returns the identification byte (default 0xC3).
- R2: A 0-to-1 transition on line n sets status bit 0 (change flag) when bit n%8 of the rise-enable register of port n/8 (offset 0x42 + 0x10 x port) is 1 and control bit 3 is 1.
- R3: A 1-to-0 transition on line n sets status bit 0 when bit n%8 of the fall-enable register of port n/8 (offset 0x43 + 0x10 x port) is 1 and control bit 4 is 1.
- R4: A transition whose line enable bit is 0, or whose direction select in control bit 3 (rise) or bit 4 (fall) is 0, leaves the status register unchanged.
- R5: A qualifying transition that arrives while status bit 0 is already set sets status bit 1 (missed-change flag), which then holds until cleared.
- R6: A write to offset 0x01 with bit 3 set clears status bit 0 only; with bit 2 set it clears status bit 1 only. Bits written as 0 have no effect.
- R7: When a clear of the change flag and a new qualifying transition land in the same clock cycle, the change flag ends up set.
- R8: The interrupt output, mirrored in status bit 2, is 1 exactly when control bit 2 (master) is 1 and either status bit 0 with control bit 0 or status bit 1 with control bit 1 is 1. It follows the flags and control bits one clock later.
- R9: The enable registers read back what was written. The control register reads back the low five bits written. Writes to offsets 0x00 and 0x02 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| lines_in | input | NUM_PORTS x PORT_W (32) | Asynchronous monitored lines |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench walks every line through every combination of its two enable bits, with an up and a down transition each time. A decoder that puts a bit or a port at the wrong offset, or that swaps the rise and fall registers, therefore shows up as a flag that is set on the wrong line or missed on the right one. The direction selects are toggled separately, to catch a design that ignores them. The missed-change flag is driven both by a second transition and by the two separate clear bits, which exposes designs that clear both flags together or never set the second one. The bench also lands a clear in the very cycle a new transition is detected; a design that lets the clear win would lose that change. Finally, the interrupt is checked against each enable and the master bit, to catch designs that skip the master gate or use the wrong flag.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] OFS_ID      = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CLR     = 8'h01;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 8'h02;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h03;
  localparam logic [ADDR_W-1:0] OFS_RISE0   = 8'h42;
  localparam logic [ADDR_W-1:0] OFS_FALL0   = 8'h43;
  localparam logic [ADDR_W-1:0] PORT_STRIDE = 8'h10;

  localparam int CLR_EDGE_BIT = 3;
  localparam int CLR_OVF_BIT  = 2;

  // packed order gives fall_sel = bit 4 down to edge_ie = bit 0
  typedef struct packed {
    logic fall_sel;
    logic rise_sel;
    logic master;
    logic ovf_ie;
    logic edge_ie;
  } ctrl_t;
endpackage

// File: rtl/chg_sync_detect.sv
module chg_sync_detect #(
  parameter int LINES  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] rise_ev,
  output logic [LINES-1:0] fall_ev
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] sh;
    logic              prev;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        sh   <= {sh[STAGES-2:0], din[i]};
        prev <= sh[STAGES-1];
      end
    end
    assign rise_ev[i] =  sh[STAGES-1] & ~prev;
    assign fall_ev[i] = ~sh[STAGES-1] &  prev;
  end
endmodule

// File: rtl/chg_event_flags.sv
module chg_event_flags
  import chg_irq_pkg::*;
#(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] rise_ev,
  input  logic [LINES-1:0] fall_ev,
  input  logic [LINES-1:0] rise_en,
  input  logic [LINES-1:0] fall_en,
  input  ctrl_t            ctrl,
  input  logic             clr_edge,
  input  logic             clr_ovf,
  output logic             edge_flag,
  output logic             ovf_flag,
  output logic             irq
);
  logic hit;

  assign hit = ((|(rise_ev & rise_en)) & ctrl.rise_sel) |
               ((|(fall_ev & fall_en)) & ctrl.fall_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_flag <= 1'b0;
      ovf_flag  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      // a fresh detection outranks a clear in the same cycle
      edge_flag <= hit | (edge_flag & ~clr_edge);
      ovf_flag  <= (hit & edge_flag) | (ovf_flag & ~clr_ovf);
      irq       <= ctrl.master & ((edge_flag & ctrl.edge_ie) |
                                  (ovf_flag  & ctrl.ovf_ie));
    end
  end

  AST_EDGE_SET: assert property (@(posedge clk) disable iff (rst)
    hit |=> edge_flag);                                   // R2
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (hit && edge_flag) |=> ovf_flag);                     // R5
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !clr_ovf) |=> ovf_flag);                 // R5
  AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr_edge && !hit) |=> !edge_flag);                   // R6
  AST_IRQ_MASTER: assert property (@(posedge clk) disable iff (rst)
    !ctrl.master |=> !irq);                               // R8
endmodule

// File: rtl/chg_reg_file.sv
module chg_reg_file
  import chg_irq_pkg::*;
#(
  parameter int                NUM_PORTS = 4,
  parameter int                PORT_W    = 8,
  parameter logic [DATA_W-1:0] ID_VALUE  = 8'hC3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        wr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        edge_flag,
  input  logic                        ovf_flag,
  input  logic                        irq,
  output logic [DATA_W-1:0]           rdata,
  output logic [NUM_PORTS*PORT_W-1:0] rise_en,
  output logic [NUM_PORTS*PORT_W-1:0] fall_en,
  output ctrl_t                       ctrl,
  output logic                        clr_edge,
  output logic                        clr_ovf
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [DATA_W-1:0] port_rd [NUM_PORTS];
  logic [DATA_W-1:0] port_or;
  logic [DATA_W-1:0] rd_mux;
  ctrl_t             ctrl_q;
  logic [CTRL_W-1:0] ctrl_bits;
  logic              ctrl_wr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] A_RISE = OFS_RISE0 + ADDR_W'(p) * PORT_STRIDE;
    localparam logic [ADDR_W-1:0] A_FALL = OFS_FALL0 + ADDR_W'(p) * PORT_STRIDE;
    logic [PORT_W-1:0] rq, fq;
    always_ff @(posedge clk) begin
      if (rst) begin
        rq <= '0;
        fq <= '0;
      end else if (wr) begin
        if (addr == A_RISE) rq <= wdata[PORT_W-1:0];
        if (addr == A_FALL) fq <= wdata[PORT_W-1:0];
      end
    end
    assign rise_en[p*PORT_W +: PORT_W] = rq;
    assign fall_en[p*PORT_W +: PORT_W] = fq;
    assign port_rd[p] = ((addr == A_RISE) ? DATA_W'(rq) : '0) |
                        ((addr == A_FALL) ? DATA_W'(fq) : '0);
  end

  assign ctrl_wr = wr && (addr == OFS_CTRL);

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
  end
  assign ctrl      = ctrl_q;
  assign ctrl_bits = ctrl_q;

  assign clr_edge = wr && (addr == OFS_CLR) && wdata[CLR_EDGE_BIT];
  assign clr_ovf  = wr && (addr == OFS_CLR) && wdata[CLR_OVF_BIT];

  always_comb begin
    port_or = '0;
    for (int p = 0; p < NUM_PORTS; p++) port_or = port_or | port_rd[p];
  end

  always_comb begin
    case (addr)
      OFS_ID:   rd_mux = ID_VALUE;
      OFS_STAT: rd_mux = DATA_W'({irq, ovf_flag, edge_flag});
      OFS_CTRL: rd_mux = DATA_W'(ctrl_bits);
      OFS_CLR:  rd_mux = '0;
      default:  rd_mux = port_or;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (ctrl_bits == $past(wdata[CTRL_W-1:0])));  // R9
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ctrl_wr |=> $stable(ctrl_bits));                      // R9
endmodule

// File: rtl/chg_irq_unit.sv
module chg_irq_unit
  import chg_irq_pkg::*;
#(
  parameter int                NUM_PORTS   = 4,
  parameter int                PORT_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_VALUE    = 8'hC3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] lines_in,
  output logic                        irq
);
  localparam int LINES = NUM_PORTS * PORT_W;

  logic [LINES-1:0] rise_ev, fall_ev, rise_en, fall_en;
  ctrl_t            ctrl;
  logic             clr_edge, clr_ovf, edge_flag, ovf_flag;

  chg_sync_detect #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_detect (
    .clk(clk), .rst(rst), .din(lines_in),
    .rise_ev(rise_ev), .fall_ev(fall_ev)
  );

  chg_event_flags #(.LINES(LINES)) u_flags (
    .clk(clk), .rst(rst),
    .rise_ev(rise_ev), .fall_ev(fall_ev),
    .rise_en(rise_en), .fall_en(fall_en),
    .ctrl(ctrl), .clr_edge(clr_edge), .clr_ovf(clr_ovf),
    .edge_flag(edge_flag), .ovf_flag(ovf_flag), .irq(irq)
  );

  chg_reg_file #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ID_VALUE(ID_VALUE)) u_regs (
    .clk(clk), .rst(rst),
    .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .edge_flag(edge_flag), .ovf_flag(ovf_flag), .irq(irq),
    .rdata(bus_rdata), .rise_en(rise_en), .fall_en(fall_en),
    .ctrl(ctrl), .clr_edge(clr_edge), .clr_ovf(clr_ovf)
  );
endmodule

// File: tb/chg_irq_unit_test.sv
module chg_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] lines_in = '0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  chg_irq_unit uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lines_in(lines_in), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic set_lines(input logic [31:0] v);
    @(negedge clk);
    lines_in = v;
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [7:0] rise_addr(input int p);
    return 8'h42 + 8'(p) * 8'h10;
  endfunction
  function automatic logic [7:0] fall_addr(input int p);
    return 8'h43 + 8'(p) * 8'h10;
  endfunction

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] e;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd_reg(8'h02, d); chk("R1 status", {24'b0, d}, 32'h0);
    rd_reg(8'h03, d); chk("R1 ctrl", {24'b0, d}, 32'h0);
    rd_reg(8'h00, d); chk("R1 id", {24'b0, d}, 32'hC3);
    for (int p = 0; p < 4; p++) begin
      rd_reg(rise_addr(p), d); chk("R1 rise en", {24'b0, d}, 32'h0);
      rd_reg(fall_addr(p), d); chk("R1 fall en", {24'b0, d}, 32'h0);
    end

    // R9 register readback and ignored writes
    for (int p = 0; p < 4; p++) begin
      wr_reg(rise_addr(p), 8'(8'h5A + p));
      wr_reg(fall_addr(p), 8'(8'hA5 - p));
    end
    for (int p = 0; p < 4; p++) begin
      rd_reg(rise_addr(p), d); chk("R9 rise readback", {24'b0, d}, {24'b0, 8'(8'h5A + p)});
      rd_reg(fall_addr(p), d); chk("R9 fall readback", {24'b0, d}, {24'b0, 8'(8'hA5 - p)});
    end
    wr_reg(8'h03, 8'hE3);
    rd_reg(8'h03, d); chk("R9 ctrl five bits", {24'b0, d}, 32'h03);
    wr_reg(8'h00, 8'h11);
    rd_reg(8'h00, d); chk("R9 id write ignored", {24'b0, d}, 32'hC3);
    wr_reg(8'h02, 8'hFF);
    rd_reg(8'h02, d); chk("R9 status write ignored", {24'b0, d}, 32'h0);

    // R2 R3 R4 R5 sweep over every line and enable pair
    wr_reg(8'h03, 8'h18);
    for (int i = 0; i < 32; i++) begin
      for (int c = 0; c < 4; c++) begin
        wr_reg(rise_addr(i / 8), 8'(c % 2) << (i % 8));
        wr_reg(fall_addr(i / 8), 8'(c / 2) << (i % 8));
        wr_reg(8'h01, 8'h0C);
        set_lines(32'h1 << i);
        rd_reg(8'h02, d);
        e = {7'b0, 1'(c % 2)};
        chk((c % 2) ? "R2 rise sets flag" : "R4 rise ignored", {24'b0, d}, {24'b0, e});
        set_lines(32'h0);
        rd_reg(8'h02, d);
        e = {6'b0, 1'(c == 3), 1'(c != 0)};
        chk((c == 3) ? "R5 overflow" : ((c / 2) ? "R3 fall sets flag" : "R4 fall ignored"),
            {24'b0, d}, {24'b0, e});
      end
    end

    // R4 direction selects gate each kind of transition
    wr_reg(8'h42, 8'hFF);
    wr_reg(8'h43, 8'hFF);
    wr_reg(8'h01, 8'h0C);
    wr_reg(8'h03, 8'h10);
    set_lines(32'h1);
    rd_reg(8'h02, d); chk("R4 rise select off", {24'b0, d}, 32'h0);
    wr_reg(8'h03, 8'h08);
    set_lines(32'h0);
    rd_reg(8'h02, d); chk("R4 fall select off", {24'b0, d}, 32'h0);

    // R6 independent clears
    wr_reg(8'h03, 8'h18);
    set_lines(32'h1); set_lines(32'h0);
    rd_reg(8'h02, d); chk("R6 setup both flags", {24'b0, d}, 32'h03);
    wr_reg(8'h01, 8'h08);
    rd_reg(8'h02, d); chk("R6 clear change only", {24'b0, d}, 32'h02);
    wr_reg(8'h01, 8'h04);
    rd_reg(8'h02, d); chk("R6 clear missed", {24'b0, d}, 32'h0);
    set_lines(32'h1); set_lines(32'h0);
    wr_reg(8'h01, 8'h04);
    rd_reg(8'h02, d); chk("R6 clear missed only", {24'b0, d}, 32'h01);
    wr_reg(8'h01, 8'hF3);
    rd_reg(8'h02, d); chk("R6 zero bits no effect", {24'b0, d}, 32'h01);
    wr_reg(8'h01, 8'h0C);

    // R7 clear and new transition in the same cycle
    @(negedge clk); lines_in = 32'h1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h01; bus_wdata = 8'h08; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    rd_reg(8'h02, d); chk("R7 new edge wins", {24'b0, d}, 32'h01);
    set_lines(32'h0);
    wr_reg(8'h01, 8'h0C);

    // R8 interrupt gating
    wr_reg(8'h03, 8'h0D);
    set_lines(32'h1);
    rd_reg(8'h02, d); chk("R8 status master pending", {24'b0, d}, 32'h05);
    chk("R8 irq on change", {31'b0, irq}, 32'h1);
    wr_reg(8'h01, 8'h08);
    rd_reg(8'h02, d);
    chk("R8 irq drops after clear", {31'b0, irq}, 32'h0);
    set_lines(32'h0);
    wr_reg(8'h03, 8'h0E);
    set_lines(32'h1);
    rd_reg(8'h02, d); chk("R8 change without its enable", {24'b0, d}, 32'h01);
    chk("R8 irq off without enable", {31'b0, irq}, 32'h0);
    wr_reg(8'h03, 8'h1E);
    set_lines(32'h0);
    rd_reg(8'h02, d); chk("R8 missed-change irq", {24'b0, d}, 32'h07);
    chk("R8 irq on missed change", {31'b0, irq}, 32'h1);
    wr_reg(8'h03, 8'h1B);
    rd_reg(8'h02, d); chk("R8 master off status", {24'b0, d}, 32'h03);
    chk("R8 master off irq", {31'b0, irq}, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule